// File: doc/BRIEF.md
# Sierpinski GF(2) Subset-Parity Transform

This block multiplies an n-bit vector by the lower-triangular Sierpinski gasket matrix over GF(2), with n = 2^K. Output bit i is the XOR of every input bit j whose index is a bit-subset of i. Index 0 is the first row and the first column. The matrix is built recursively: the order-0 matrix is (1). Each higher order is a two-by-two block matrix. Its upper-right block is zero, and the order-below matrix fills the other three blocks. Because the matrix has determinant 1, the mapping is a bijection. Over GF(2) it is also its own inverse.

The datapath is a network of two-input XOR gates only, arranged in K stages of n/2 gates each. Each stage merges the result of one half into the other half at one recursion level. The top half is reused for the bottom half rather than recomputed. That gives exactly (n/2)·K gates with no cancellation.

Data enters and leaves on a valid/ready stream. With REG_OUT = 1, one output register holds the result, so there is a one-cycle latency. In that mode a beat is accepted whenever the register is empty or is being drained in the same cycle. A held beat stays unchanged while the consumer stalls. With REG_OUT = 0, the path is purely combinational and ready passes straight from output to input.

Top module: `sgx_transform`

## Requirements
- R1: For every input vector, out_data bit i equals the XOR of in_data bits j for which (j AND NOT i) == 0. Bit index 0 is row and column 0.
- R2: out_data bit 0 always equals in_data bit 0, and out_data bit n-1 equals the parity of all n input bits.
- R3: The lower n/2 output bits depend only on the lower n/2 input bits. Changing the upper input half leaves them unchanged.
- R4: Applying the transform twice returns the original vector.
- R5: With REG_OUT = 1, a beat accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high after that edge. If out_valid and out_ready are high and no beat is accepted, out_valid is low after the edge.
- R6: With REG_OUT = 1, while out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: With REG_OUT = 1, in_ready is high exactly when out_valid is low or out_ready is high.
- R8: With REG_OUT = 1, a synchronous active-high rst clears out_valid and out_data to zero at the next clock edge.
- R9: With REG_OUT = 0, out_valid follows in_valid and in_ready follows out_ready in the same cycle, and out_data is the transform of the present in_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 2^K | Input vector, bit 0 is element 0 |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 2^K | Transformed vector |

## Verification
The bench builds three instances. The first has K = 4 and REG_OUT = 1, which makes every one of the 65536 inputs reachable through the output register. Stalls, drains and a reset in mid-stream are also applied to it. The second and third have K = 6 and REG_OUT = 0 and are chained back to back: random and directed 64-bit vectors check the subset-parity rule, the half-independence and the self-inverse property in one pass.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  // stream side selected for the output stage
  typedef enum logic {SGX_COMB = 1'b0, SGX_REG = 1'b1} sgx_mode_e;

  // number of two-input XOR gates for a width of 2**k
  function automatic int unsigned sgx_gate_count(input int unsigned k);
    return (k == 0) ? 0 : ((1 << k) / 2) * k;
  endfunction
endpackage

// File: rtl/sgx_stage.sv
// One recursion level: every element whose index has bit LVL set takes
// its partner from the other half of its 2**(LVL+1) block.
module sgx_stage #(
  parameter int unsigned N   = 16,
  parameter int unsigned LVL = 0
) (
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  localparam int unsigned STRIDE = 1 << LVL;

  for (genvar i = 0; i < N; i++) begin : g_el
    if (((i >> LVL) & 1) == 1) begin : g_mix
      assign q[i] = d[i] ^ d[i - STRIDE];
    end else begin : g_pass
      assign q[i] = d[i];
    end
  end
endmodule

// File: rtl/sgx_network.sv
module sgx_network #(
  parameter int unsigned K = 4
) (
  input  logic [(1<<K)-1:0] x,
  output logic [(1<<K)-1:0] y
);
  localparam int unsigned N = 1 << K;

  logic [N-1:0] lvl [0:K];

  assign lvl[0] = x;

  for (genvar s = 0; s < K; s++) begin : g_lvl
    sgx_stage #(.N(N), .LVL(s)) u_stage (
      .d(lvl[s]),
      .q(lvl[s+1])
    );
  end

  assign y = lvl[K];
endmodule

// File: rtl/sgx_out_stage.sv
module sgx_out_stage #(
  parameter int unsigned W       = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  import sgx_pkg::*;
  localparam sgx_mode_e MODE = REG_OUT ? SGX_REG : SGX_COMB;

  if (MODE == SGX_REG) begin : g_reg
    logic         full_q;
    logic [W-1:0] data_q;

    assign in_ready = !full_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end

    assign out_valid = full_q;
    assign out_data  = data_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

  // R6: a stalled beat is held
  p_hold_r6: assert property (@(posedge clk) disable iff (rst || (MODE == SGX_COMB))
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("p_hold_r6");

  // R5: an accepted beat shows up after the edge
  p_fill_r5: assert property (@(posedge clk) disable iff (rst || (MODE == SGX_COMB))
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)))
    else $error("p_fill_r5");

  // R5: drained with nothing new leaves the stage empty
  p_drain_r5: assert property (@(posedge clk) disable iff (rst || (MODE == SGX_COMB))
    (out_valid && out_ready && !in_valid) |=> !out_valid)
    else $error("p_drain_r5");
endmodule

// File: rtl/sgx_transform.sv
module sgx_transform #(
  parameter int unsigned K       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [(1<<K)-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [(1<<K)-1:0] out_data
);
  localparam int unsigned N = 1 << K;

  logic [N-1:0] net_y;

  sgx_network #(.K(K)) u_net (
    .x(in_data),
    .y(net_y)
  );

  sgx_out_stage #(.W(N), .REG_OUT(REG_OUT)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (net_y),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  // R2: first row is the identity, last row is full parity
  p_corner_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (net_y[0] == in_data[0] && net_y[N-1] == ^in_data))
    else $error("p_corner_r2");

  // R9: combinational mode delivers the transform in the same cycle
  p_comb_r9: assert property (@(posedge clk) disable iff (rst || REG_OUT)
    in_valid |-> (out_valid && out_data[0] == in_data[0] && out_data[N-1] == ^in_data))
    else $error("p_comb_r9");
endmodule

// File: tb/sim_sgx_transform.sv
module sim_sgx_transform;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  // instance u0: K=4, registered
  logic        a_iv = 1'b0, a_or = 1'b1;
  logic        a_ir, a_ov;
  logic [15:0] a_in = '0, a_out;
  // instance u1/u2: K=6, combinational, chained
  logic        b_iv = 1'b0, b_or = 1'b1;
  logic        b_ir, b_ov, c_ir, c_ov;
  logic [63:0] b_in = '0, b_out, c_out;

  sgx_transform #(.K(4), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir), .in_data(a_in),
    .out_valid(a_ov), .out_ready(a_or), .out_data(a_out));

  sgx_transform #(.K(6), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir), .in_data(b_in),
    .out_valid(b_ov), .out_ready(b_or), .out_data(b_out));

  sgx_transform #(.K(6), .REG_OUT(1'b0)) u2 (
    .clk(clk), .rst(rst), .in_valid(b_ov), .in_ready(c_ir), .in_data(b_out),
    .out_valid(c_ov), .out_ready(b_or), .out_data(c_out));

  function automatic logic [63:0] ref_tf(input logic [63:0] x, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if ((j & ~i) == 0) r[i] = r[i] ^ x[j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic comb_vec(input logic [63:0] v);
    logic [63:0] e;
    b_in = v;
    #1;
    e = ref_tf(v, 64);
    chk(b_out == e, "R1", b_out, e);
    chk(b_out[0] == v[0] && b_out[63] == ^v, "R2", b_out, e);
    chk(c_out == v, "R4", c_out, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] lo, e;
    logic [15:0] hold;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state
    chk(a_ov == 1'b0 && a_out == '0, "R8", {47'd0, a_ov, a_out}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R5, R1: exhaustive through the register, one beat per cycle
    a_iv = 1'b1;
    a_or = 1'b1;
    for (int v = 0; v < 65536; v++) begin
      a_in = v[15:0];
      @(posedge clk);
      #2;
      e = ref_tf({48'd0, v[15:0]}, 16);
      chk(a_ov == 1'b1, "R5", {63'd0, a_ov}, 64'd1);
      chk(a_out == e[15:0], "R1", {48'd0, a_out}, e);
      @(negedge clk);
    end

    // R6, R7: stall with a second beat waiting
    a_or = 1'b0;
    a_in = 16'h00ff;
    #1;
    chk(a_ir == 1'b0, "R7", {63'd0, a_ir}, 64'd0);
    hold = a_out;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #2;
      chk(a_ov == 1'b1 && a_out == hold, "R6", {48'd0, a_out}, {48'd0, hold});
      chk(a_ir == 1'b0, "R7", {63'd0, a_ir}, 64'd0);
    end
    @(negedge clk);
    a_or = 1'b1;
    #1;
    chk(a_ir == 1'b1, "R7", {63'd0, a_ir}, 64'd1);
    @(posedge clk);
    #2;
    e = ref_tf(64'h00ff, 16);
    chk(a_ov == 1'b1 && a_out == e[15:0], "R5", {48'd0, a_out}, e);
    // R5: drain with no new beat
    @(negedge clk);
    a_iv = 1'b0;
    @(posedge clk);
    #2;
    chk(a_ov == 1'b0, "R5", {63'd0, a_ov}, 64'd0);
    @(negedge clk);
    #1;
    chk(a_ir == 1'b1, "R7", {63'd0, a_ir}, 64'd1);

    // R8: reset while holding data
    a_iv = 1'b1;
    a_in = 16'hbeef;
    @(posedge clk);
    @(negedge clk);
    a_iv = 1'b0;
    a_or = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #2;
    chk(a_ov == 1'b0 && a_out == '0, "R8", {47'd0, a_ov, a_out}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    a_or = 1'b1;

    // R9: combinational handshake passes straight through
    b_iv = 1'b1;
    b_or = 1'b0;
    b_in = 64'h0123_4567_89ab_cdef;
    #1;
    chk(b_ov == 1'b1 && b_ir == 1'b0, "R9", {62'd0, b_ov, b_ir}, 64'd2);
    e = ref_tf(b_in, 64);
    chk(b_out == e, "R9", b_out, e);
    b_or = 1'b1;
    #1;
    chk(b_ir == 1'b1, "R9", {63'd0, b_ir}, 64'd1);

    // directed corners on the 64-bit path
    comb_vec(64'd0);
    comb_vec({64{1'b1}});
    comb_vec({32{2'b01}});
    comb_vec({32{2'b10}});
    for (int b = 0; b < 64; b++) comb_vec(64'd1 << b);

    // R3: lower output half unchanged when only the upper input half moves
    lo = {32'd0, $urandom};
    b_in = lo;
    #1;
    e = b_out;
    for (int t = 0; t < 8; t++) begin
      b_in = {$urandom, lo[31:0]};
      #1;
      chk(b_out[31:0] == e[31:0], "R3", {32'd0, b_out[31:0]}, {32'd0, e[31:0]});
    end

    // random vectors
    for (int t = 0; t < 10000; t++) comb_vec({$urandom, $urandom});

    finish_run();
  end
endmodule